// File: doc/BRIEF.md
# Three-Way Miss Cause Classifier

This block is a passive monitor placed beside a stream of memory block references. For every reference it reports the cause of that reference's outcome. It keeps three structures that all update together:

- a tag-only model of a set-associative cache;
- a fully associative shadow tag store of equal capacity and block size;
- a bitmap that marks every block touched since reset.

A reference to an untouched block is a compulsory miss. A repeat reference that finds its block in the modelled cache is a hit. A repeat reference that misses the modelled cache is a capacity miss when the shadow store also lacks the block. It is a conflict miss when the shadow store still holds the block.

The monitor takes one reference per cycle as a valid strobe plus a block address. It holds no data, tracks no write-back traffic and models no backing memory. The classification code appears one cycle after the reference. Four running counters report total references and the number of each miss class. The three miss counters together give the modelled cache's miss count.

The geometry is set by parameters. `WAYS` is the associativity and `LINES` is the capacity divided by the block size. The modelled cache has `LINES/WAYS` sets and the shadow store has `LINES` ways. All geometry values are powers of two.

Top module: `c3c_classifier`

## Requirements
- R1: After reset, `cls_valid` is 0 and all four counters read 0.
- R2: `cls_valid` is 1 in exactly the cycle after a cycle with `ref_valid` high. While `ref_valid` is low, `ref_blk` is ignored and no counter changes.
- R3: The first reference to a block since reset gives `cls_code` 2'b01 (compulsory).
- R4: A repeat reference to a block held in the modelled cache gives `cls_code` 2'b00 (hit).
- R5: The modelled cache picks a set as `ref_blk mod (LINES/WAYS)` and stores `ref_blk / (LINES/WAYS)` as the tag. Blocks in different sets never evict each other, and blocks in one set with different tags occupy separate ways.
- R6: A repeat reference is a conflict miss (`cls_code` 2'b11) when it misses the modelled cache but hits the shadow store.
- R7: A repeat reference is a capacity miss (`cls_code` 2'b10) when it misses both the modelled cache and the shadow store.
- R8: Both stores use true LRU replacement. The recency order is updated on hits as well as on fills, and a miss fills the least recently used way.
- R9: `cnt_refs` rises by one per accepted reference. `cnt_compulsory`, `cnt_capacity` and `cnt_conflict` each rise by one per reference of their own class. The counters update in the same cycle that the code appears.
- R10: Every counter saturates at 2^CNT_W-1 and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_valid | input | 1 | A reference is presented this cycle |
| ref_blk | input | ADDR_W | Block address of the reference |
| cls_valid | output | 1 | `cls_code` is valid this cycle |
| cls_code | output | 2 | 00 hit, 01 compulsory, 10 capacity, 11 conflict |
| cnt_refs | output | CNT_W | Total references, saturating |
| cnt_compulsory | output | CNT_W | Compulsory misses, saturating |
| cnt_capacity | output | CNT_W | Capacity misses, saturating |
| cnt_conflict | output | CNT_W | Conflict misses, saturating |

## Verification
The assertions assume the following about the inputs:

- `ref_valid` is low throughout reset and for the synchronizer cycles that follow it.
- `ref_blk` is stable and within `ADDR_W` bits whenever `ref_valid` is high.
- Geometry parameters are powers of two, with `WAYS` dividing `LINES`.

The stimulus changes inputs only on the falling clock edge. It holds `ref_valid` low across every reset pulse and waits out the synchronizer before the first reference. Each scenario starts from a fresh reset, so the expected class of every reference can be derived by hand from the LRU order.

// File: rtl/c3c_pkg.sv
package c3c_pkg;

  typedef enum logic [1:0] {
    CLS_HIT  = 2'b00,
    CLS_COMP = 2'b01,
    CLS_CAP  = 2'b10,
    CLS_CONF = 2'b11
  } ref_class_e;

  localparam int unsigned NUM_COUNTERS = 4;

endpackage

// File: rtl/c3c_tag_store.sv
module c3c_tag_store #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned SETS   = 4,
  parameter int unsigned WAYS   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              hit
);

  localparam int unsigned SET_BITS   = $clog2(SETS);
  localparam int unsigned TAG_W      = ADDR_W - SET_BITS;
  localparam int unsigned IDX_W      = (SET_BITS > 0) ? SET_BITS : 1;
  localparam int unsigned SETS_ALLOC = 1 << IDX_W;
  localparam int unsigned AGE_W      = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [IDX_W-1:0] set_idx;
  logic [TAG_W-1:0] acc_tag;

  logic             vld_q [SETS_ALLOC][WAYS];
  logic             vld_d [SETS_ALLOC][WAYS];
  logic [TAG_W-1:0] tag_q [SETS_ALLOC][WAYS];
  logic [AGE_W-1:0] age_q [SETS_ALLOC][WAYS];
  logic [AGE_W-1:0] age_d [SETS_ALLOC][WAYS];

  logic [WAYS-1:0]  match;
  logic [WAYS-1:0]  oldest;
  logic [AGE_W-1:0] hit_way;
  logic [AGE_W-1:0] victim_way;
  logic [AGE_W-1:0] use_way;
  logic [AGE_W-1:0] use_age;

  generate
    if (SET_BITS > 0) begin : g_multi_set
      assign set_idx = acc_addr[SET_BITS-1:0];
    end else begin : g_single_set
      assign set_idx = '0;
    end
  endgenerate

  assign acc_tag = acc_addr[ADDR_W-1:SET_BITS];

  genvar gw;
  generate
    for (gw = 0; gw < WAYS; gw++) begin : g_way
      assign match[gw]  = vld_q[set_idx][gw] && (tag_q[set_idx][gw] == acc_tag);
      assign oldest[gw] = (age_q[set_idx][gw] == AGE_W'(WAYS - 1));
    end
  endgenerate

  assign hit = |match;

  always_comb begin
    hit_way    = '0;
    victim_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (match[w])  hit_way    = AGE_W'(w);
      if (oldest[w]) victim_way = AGE_W'(w);
    end
  end

  assign use_way = hit ? hit_way : victim_way;
  assign use_age = age_q[set_idx][use_way];

  // next state: touched way becomes youngest, younger ways age by one
  always_comb begin
    vld_d = vld_q;
    age_d = age_q;
    if (acc_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (AGE_W'(w) == use_way) begin
          age_d[set_idx][w] = '0;
        end else if (age_q[set_idx][w] < use_age) begin
          age_d[set_idx][w] = age_q[set_idx][w] + 1'b1;
        end
      end
      if (!hit) vld_d[set_idx][use_way] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS_ALLOC; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          vld_q[s][w] <= 1'b0;
          age_q[s][w] <= AGE_W'(w);
        end
      end
    end else if (acc_en) begin
      vld_q <= vld_d;
      age_q <= age_d;
    end
  end

  // tag array carries no reset; valid bits qualify it
  always_ff @(posedge clk) begin
    if (acc_en && !hit) begin
      tag_q[set_idx][use_way] <= acc_tag;
    end
  end

  // R5: a tag may sit in only one way of a set
  assert_single_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en |-> $onehot0(match));

  // R8: recency ages stay a permutation, so exactly one way is the LRU
  assert_lru_unique_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en |-> ($countones(oldest) == 1));

  // R8: a referenced block is resident right after the access
  assert_fill_resident_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en |=> (vld_q[$past(set_idx)][$past(use_way)] &&
                (tag_q[$past(set_idx)][$past(use_way)] == $past(acc_tag))));

endmodule

// File: rtl/c3c_first_touch.sv
module c3c_first_touch #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mark_en,
  input  logic [ADDR_W-1:0] mark_addr,
  output logic              seen
);

  localparam int unsigned BLOCKS = 1 << ADDR_W;

  logic [BLOCKS-1:0] seen_q;
  logic [BLOCKS-1:0] seen_d;

  assign seen = seen_q[mark_addr];

  always_comb begin
    seen_d = seen_q;
    if (mark_en) seen_d[mark_addr] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
    end else if (mark_en) begin
      seen_q <= seen_d;
    end
  end

  // R3: once referenced, a block stays marked until reset
  assert_mark_sticks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mark_en |=> seen_q[$past(mark_addr)]);

endmodule

// File: rtl/c3c_counters.sv
module c3c_counters
  import c3c_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rec_en,
  input  ref_class_e       rec_cls,
  output logic [CNT_W-1:0] cnt_total,
  output logic [CNT_W-1:0] cnt_comp,
  output logic [CNT_W-1:0] cnt_cap,
  output logic [CNT_W-1:0] cnt_conf
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [1:0]             cls_bits;
  logic [NUM_COUNTERS-1:0] bump;
  logic [CNT_W-1:0]       cnt_q [NUM_COUNTERS];
  logic [CNT_W-1:0]       cnt_d [NUM_COUNTERS];

  assign cls_bits = rec_cls;

  genvar gk;
  generate
    for (gk = 0; gk < NUM_COUNTERS; gk++) begin : g_cnt
      if (gk == 0) begin : g_total
        assign bump[gk] = rec_en;
      end else begin : g_class
        assign bump[gk] = rec_en && (cls_bits == 2'(gk));
      end

      always_comb begin
        cnt_d[gk] = cnt_q[gk];
        if (bump[gk] && (cnt_q[gk] != CNT_MAX)) cnt_d[gk] = cnt_q[gk] + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q[gk] <= '0;
        end else if (bump[gk]) begin
          cnt_q[gk] <= cnt_d[gk];
        end
      end

      // R10: a full counter stays full
      assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q[gk] == CNT_MAX) |=> (cnt_q[gk] == CNT_MAX));

      // R9: a counter moves by at most one per cycle
      assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cnt_q[gk] == $past(cnt_q[gk])) ||
                  (cnt_q[gk] == $past(cnt_q[gk]) + 1'b1)));
    end
  endgenerate

  assign cnt_total = cnt_q[0];
  assign cnt_comp  = cnt_q[1];
  assign cnt_cap   = cnt_q[2];
  assign cnt_conf  = cnt_q[3];

  // R9: misses never outnumber references while the total is below saturation
  assert_miss_sum_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_total != CNT_MAX) |->
      ((CNT_W+2)'(cnt_comp) + (CNT_W+2)'(cnt_cap) + (CNT_W+2)'(cnt_conf)
        <= (CNT_W+2)'(cnt_total)));

endmodule

// File: rtl/c3c_classifier.sv
module c3c_classifier
  import c3c_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned WAYS   = 2,
  parameter int unsigned LINES  = 8,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_valid,
  input  logic [ADDR_W-1:0] ref_blk,
  output logic              cls_valid,
  output logic [1:0]        cls_code,
  output logic [CNT_W-1:0]  cnt_refs,
  output logic [CNT_W-1:0]  cnt_compulsory,
  output logic [CNT_W-1:0]  cnt_capacity,
  output logic [CNT_W-1:0]  cnt_conflict
);

  localparam int unsigned SETS = LINES / WAYS;

  logic       rst_meta_q;
  logic       rst_sync_q;
  logic       real_hit;
  logic       shadow_hit;
  logic       seen;
  ref_class_e cls_d;
  ref_class_e cls_q;
  logic       cls_valid_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  c3c_tag_store #(
    .ADDR_W (ADDR_W),
    .SETS   (SETS),
    .WAYS   (WAYS)
  ) u_real (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .acc_en   (ref_valid),
    .acc_addr (ref_blk),
    .hit      (real_hit)
  );

  c3c_tag_store #(
    .ADDR_W (ADDR_W),
    .SETS   (1),
    .WAYS   (LINES)
  ) u_shadow (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .acc_en   (ref_valid),
    .acc_addr (ref_blk),
    .hit      (shadow_hit)
  );

  c3c_first_touch #(
    .ADDR_W (ADDR_W)
  ) u_touch (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .mark_en   (ref_valid),
    .mark_addr (ref_blk),
    .seen      (seen)
  );

  always_comb begin
    if (!seen) begin
      cls_d = CLS_COMP;
    end else if (real_hit) begin
      cls_d = CLS_HIT;
    end else if (shadow_hit) begin
      cls_d = CLS_CONF;
    end else begin
      cls_d = CLS_CAP;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      cls_valid_q <= 1'b0;
    end else begin
      cls_valid_q <= ref_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      cls_q <= CLS_HIT;
    end else if (ref_valid) begin
      cls_q <= cls_d;
    end
  end

  c3c_counters #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .rec_en    (ref_valid),
    .rec_cls   (cls_d),
    .cnt_total (cnt_refs),
    .cnt_comp  (cnt_compulsory),
    .cnt_cap   (cnt_capacity),
    .cnt_conf  (cnt_conflict)
  );

  assign cls_valid = cls_valid_q;
  assign cls_code  = cls_q;

  // R2: output strobe follows the input strobe by exactly one cycle
  assert_valid_delay_R2: assert property (@(posedge clk) disable iff (!rst_sync_q)
    1'b1 |=> (cls_valid == $past(ref_valid)));

  // R3: an untouched block can never be found in the modelled cache
  assert_untouched_miss_R3: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (ref_valid && !seen) |-> !real_hit);

  // R2: idle cycles leave the reference count unchanged
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !ref_valid |=> $stable(cnt_refs));

endmodule

// File: tb/c3c_classifier_tb.sv
`timescale 1ns/1ps
module c3c_classifier_tb;

  logic        clk;
  logic        rst_n;
  logic        ref_valid;
  logic [7:0]  ref_blk;
  logic        cls_valid;
  logic [1:0]  cls_code;
  logic [31:0] cnt_refs, cnt_comp, cnt_cap, cnt_conf;
  logic        sat_valid;
  logic [1:0]  sat_code;
  logic [3:0]  sat_refs, sat_comp, sat_cap, sat_conf;

  int checks;
  int fails;
  bit done;

  localparam logic [1:0] HIT  = 2'b00;
  localparam logic [1:0] COMP = 2'b01;
  localparam logic [1:0] CAP  = 2'b10;
  localparam logic [1:0] CONF = 2'b11;

  c3c_classifier u_dut (
    .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_blk(ref_blk),
    .cls_valid(cls_valid), .cls_code(cls_code),
    .cnt_refs(cnt_refs), .cnt_compulsory(cnt_comp),
    .cnt_capacity(cnt_cap), .cnt_conflict(cnt_conf)
  );

  c3c_classifier #(.CNT_W(4)) u_sat (
    .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_blk(ref_blk),
    .cls_valid(sat_valid), .cls_code(sat_code),
    .cnt_refs(sat_refs), .cnt_compulsory(sat_comp),
    .cnt_capacity(sat_cap), .cnt_conflict(sat_conf)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic apply_reset();
    ref_valid = 1'b0;
    ref_blk   = '0;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_ref(input logic [7:0] b, input logic [1:0] exp, input string req);
    @(negedge clk);
    ref_valid = 1'b1;
    ref_blk   = b;
    @(negedge clk);
    ref_valid = 1'b0;
    check(req, "cls_valid", 32'(cls_valid), 32'd1);
    check(req, "cls_code",  32'(cls_code),  32'(exp));
  endtask

  task automatic check_counts(input string req, input int t, input int c,
                              input int p, input int f);
    check(req, "cnt_refs",       cnt_refs, 32'(t));
    check(req, "cnt_compulsory", cnt_comp, 32'(c));
    check(req, "cnt_capacity",   cnt_cap,  32'(p));
    check(req, "cnt_conflict",   cnt_conf, 32'(f));
  endtask

  task automatic t_reset_state();
    apply_reset();
    check("R1", "cls_valid", 32'(cls_valid), 32'd0);
    check_counts("R1", 0, 0, 0, 0);
  endtask

  task automatic t_idle();
    apply_reset();
    send_ref(8'd7, COMP, "R3");
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      ref_blk = 8'(i * 33 + 1);
      check("R2", "cls_valid idle", 32'(cls_valid), 32'd0);
    end
    check_counts("R2", 1, 1, 0, 0);
    send_ref(8'd7, HIT, "R4");
  endtask

  task automatic t_sets_and_tags();
    apply_reset();
    for (int i = 0; i < 8; i++) send_ref(8'(i), COMP, "R3");
    for (int i = 0; i < 8; i++) send_ref(8'(i), HIT, "R5");
    send_ref(8'h84, COMP, "R5");
    send_ref(8'h04, HIT, "R5");
    check_counts("R9", 18, 9, 0, 0);
  endtask

  task automatic t_conflict();
    apply_reset();
    send_ref(8'd0, COMP, "R3");
    send_ref(8'd4, COMP, "R3");
    send_ref(8'd8, COMP, "R3");
    send_ref(8'd0, CONF, "R6");
    check_counts("R9", 4, 3, 0, 1);
  endtask

  task automatic t_capacity();
    apply_reset();
    for (int i = 0; i < 9; i++) send_ref(8'(i), COMP, "R3");
    send_ref(8'd0, CAP, "R7");
    send_ref(8'd8, HIT, "R8");
    check_counts("R9", 11, 9, 1, 0);
  endtask

  task automatic t_lru_on_hit();
    apply_reset();
    send_ref(8'd0, COMP, "R3");
    send_ref(8'd4, COMP, "R3");
    send_ref(8'd0, HIT,  "R4");
    send_ref(8'd8, COMP, "R8");
    send_ref(8'd0, HIT,  "R8");
    send_ref(8'd4, CONF, "R8");
    check_counts("R9", 6, 3, 0, 1);
  endtask

  task automatic t_saturate();
    apply_reset();
    send_ref(8'd3, COMP, "R3");
    for (int i = 0; i < 19; i++) send_ref(8'd3, HIT, "R4");
    check("R10", "sat cnt_refs", 32'(sat_refs), 32'd15);
    check("R10", "sat cnt_compulsory", 32'(sat_comp), 32'd1);
    check("R10", "sat cls_code", 32'(sat_code), 32'(HIT));
    check("R9", "wide cnt_refs", cnt_refs, 32'd20);
  endtask

  initial begin
    checks    = 0;
    fails     = 0;
    done      = 1'b0;
    rst_n     = 1'b1;
    ref_valid = 1'b0;
    ref_blk   = '0;
    t_reset_state();
    t_idle();
    t_sets_and_tags();
    t_conflict();
    t_capacity();
    t_lru_on_hit();
    t_saturate();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule